// File: doc/BRIEF.md
# DMA Address Translation Walker

This block translates a 32-bit DMA virtual address, issued by a device identified by a 16-bit requester ID, into a 48-bit physical address. The walk has two phases. First it reads a two-level device table to find the device's page-table root. The upper byte of the requester ID selects the first-level slot, and the lower byte selects the second-level slot. It then reads a two-level page table. The leaf entry maps either an 8 KB page or an 8 MB region.

All reads are 64-bit and go through a simple request/response memory port. Only one walk is in flight at a time. A walk ends with a one-cycle response that carries either the physical address or a fault with a typed cause. A memory response that never arrives is caught by a programmable timeout. When fault reporting is enabled, the first fault is frozen in a packed status word and the interrupt line is driven. Software writes the word back to release it.

Top module: `dxw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `mem_req` and `resp_valid` are 0, `status_word` is zero and `irq` is 0.
- R2: Every table entry is valid only when bit 63 is 1, and bits 47:13 hold a page-aligned base. The first device read goes to `dt_base` (low 13 bits dropped) plus 8 times requester ID bits 15:8. The second device read goes to that entry's base plus 8 times requester ID bits 7:0.
- R3: A valid second-level device entry with bit 0 set ends the walk after two reads with a non-faulting response whose physical address equals the input address, zero-extended.
- R4: Otherwise the page number is the address divided by 8192. The first page read goes to the device entry's base plus 8 times ((page number >> 10) mod 512). The second page read goes to the first page entry's base plus 8 times (page number mod 1024).
- R5: Leaf bits 5:4 select the granularity. A value of 0 gives base bits 47:13 joined with address bits 12:0. A value of 2 gives base bits 47:23 joined with address bits 22:0. Any other value faults with cause 5.
- R6: An entry with bit 63 clear faults with a cause that names the level: 0 for the first device level, 1 for the second device level, 2 for the first page level and 3 for the leaf. A valid leaf with bit 62 (access allowed) clear faults with cause 4. A faulting response has a physical address of zero.
- R7: When reporting is enabled and no fault is held, a fault loads `status_word` with bit 63 = 1, bit 62 = 1, cause in bits 61:59, requester ID in bits 52:37 and DMA address in bits 31:0; all other bits are 0. While bit 63 is set, later faults leave the word unchanged.
- R8: `irq` equals status bit 63. With `fault_en` low, faults are still returned on the response but are not captured. A `status_wr` whose data has bit 62 clear zeroes a held word; a write with bit 62 set does nothing.
- R9: One walk is in flight at a time. `req_ready` is low from acceptance until the response. Each read is a single-cycle `mem_req`. `resp_valid` lasts exactly one cycle.
- R10: If no read data arrives within (`timeout_cfg`+1)×`TO_SCALE` cycles of waiting, the walk ends with cause 5. With the bench setting of 2 and `TO_SCALE` = 4, the response is seen 14 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_rid | input | 16 | Requester ID (bus in 15:8, devfn in 7:0) |
| req_va | input | 32 | DMA virtual address |
| resp_valid | output | 1 | One-cycle completion strobe |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_cause | output | 3 | Fault cause code |
| resp_paddr | output | 48 | Translated physical address |
| mem_req | output | 1 | 64-bit read request, one cycle |
| mem_addr | output | 48 | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| dt_base | input | 48 | First-level device table base |
| fault_en | input | 1 | Enable capture of faults into the status word |
| timeout_cfg | input | 4 | Read-wait limit setting |
| status_wr | input | 1 | Status write-back strobe |
| status_wdata | input | 64 | Status write-back data |
| status_word | output | 64 | Packed sticky fault status |
| irq | output | 1 | Fault interrupt |

## Verification
The hardest situation to reach from the ports is a second fault that arrives while an earlier one is still held. The walk itself completes normally and reports the new cause, but the status word must stay frozen. The bench reaches this in three steps. It first breaks the first-level device slot and runs a walk to capture a cause-0 fault. It then breaks only the second-level device slot of the same device and walks again. Finally it compares the status word bit for bit with the first capture. The timeout case is reached by muting the bench memory responder and shrinking `timeout_cfg`.

// File: rtl/dxw_pkg.sv
package dxw_pkg;
  localparam int PA_W       = 48;
  localparam int VA_W       = 32;
  localparam int RID_W      = 16;
  localparam int PG_SHIFT   = 13;
  localparam int HUGE_SHIFT = 23;
  localparam int IDX_W      = 10;
  localparam int ENT_W      = 64;

  typedef enum logic [2:0] {
    CZ_DEV_L1  = 3'd0,
    CZ_DEV_L2  = 3'd1,
    CZ_PG_L1   = 3'd2,
    CZ_PG_L2   = 3'd3,
    CZ_DENIED  = 3'd4,
    CZ_BADRESP = 3'd5
  } cause_t;

  typedef enum logic [1:0] {
    LV_DEV1 = 2'd0,
    LV_DEV2 = 2'd1,
    LV_PG1  = 2'd2,
    LV_PG2  = 2'd3
  } level_t;

  // Page-aligned base carried in an entry.
  function automatic logic [PA_W-1:0] ent_base(input logic [ENT_W-1:0] e);
    return {e[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
  endfunction

  function automatic logic [PA_W-1:0] page_align(input logic [PA_W-1:0] a);
    return {a[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
  endfunction

  function automatic logic [IDX_W-1:0] pg_top_idx(input logic [VA_W-1:0] va);
    logic [VA_W-1:0] vpn;
    vpn = va >> PG_SHIFT;
    return IDX_W'((vpn >> 10) & 32'h1FF);
  endfunction

  function automatic logic [IDX_W-1:0] pg_leaf_idx(input logic [VA_W-1:0] va);
    logic [VA_W-1:0] vpn;
    vpn = va >> PG_SHIFT;
    return IDX_W'(vpn & 32'h3FF);
  endfunction

  function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] base,
                                                 input logic [IDX_W-1:0] idx);
    return base + {{(PA_W-IDX_W-3){1'b0}}, idx, 3'b000};
  endfunction

  function automatic logic [PA_W-1:0] leaf_pa(input logic [ENT_W-1:0] e,
                                               input logic [VA_W-1:0] va,
                                               input logic huge);
    logic [PA_W-1:0] b;
    logic [PA_W-1:0] v;
    b = ent_base(e);
    v = {{(PA_W-VA_W){1'b0}}, va};
    if (huge) return {b[PA_W-1:HUGE_SHIFT], v[HUGE_SHIFT-1:0]};
    return {b[PA_W-1:PG_SHIFT], v[PG_SHIFT-1:0]};
  endfunction

  function automatic logic [ENT_W-1:0] pack_status(input cause_t c,
                                                    input logic [RID_W-1:0] rid,
                                                    input logic [VA_W-1:0] va);
    return {1'b1, 1'b1, c, 6'b0, rid, 5'b0, va};
  endfunction
endpackage

// File: rtl/dxw_addr_gen.sv
module dxw_addr_gen
  import dxw_pkg::*;
(
  input  level_t            lvl,
  input  logic [PA_W-1:0]   base,
  input  logic [RID_W-1:0]  rid,
  input  logic [VA_W-1:0]   va,
  output logic [PA_W-1:0]   addr
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    unique case (lvl)
      LV_DEV1: idx = {2'b00, rid[15:8]};
      LV_DEV2: idx = {2'b00, rid[7:0]};
      LV_PG1:  idx = pg_top_idx(va);
      default: idx = pg_leaf_idx(va);
    endcase
    addr = slot_addr(base, idx);
  end
endmodule

// File: rtl/dxw_entry_dec.sv
module dxw_entry_dec
  import dxw_pkg::*;
(
  input  level_t            lvl,
  input  logic [ENT_W-1:0]  entry,
  input  logic [VA_W-1:0]   va,
  output logic              is_fault,
  output logic              is_final,
  output logic              pass_hit,
  output cause_t            cause,
  output logic [PA_W-1:0]   pa,
  output logic [PA_W-1:0]   next_base
);
  localparam int VALID_BIT = 63;
  localparam int ALLOW_BIT = 62;
  logic       ent_ok;
  logic [1:0] gran;
  logic       unused_hi;

  assign ent_ok    = entry[VALID_BIT];
  assign gran      = entry[5:4];
  assign next_base = ent_base(entry);
  assign unused_hi = ^{entry[61:48], entry[12:6], entry[3:1]};

  always_comb begin
    is_fault = 1'b0;
    is_final = 1'b0;
    pass_hit = 1'b0;
    cause    = CZ_DEV_L1;
    pa       = '0;
    if (!ent_ok) begin
      is_fault = 1'b1;
      unique case (lvl)
        LV_DEV1: cause = CZ_DEV_L1;
        LV_DEV2: cause = CZ_DEV_L2;
        LV_PG1:  cause = CZ_PG_L1;
        default: cause = CZ_PG_L2;
      endcase
    end else if (lvl == LV_DEV2 && entry[0]) begin
      is_final = 1'b1;
      pass_hit = 1'b1;
      pa       = {{(PA_W-VA_W){1'b0}}, va};
    end else if (lvl == LV_PG2) begin
      if (!entry[ALLOW_BIT]) begin
        is_fault = 1'b1;
        cause    = CZ_DENIED;
      end else if (gran == 2'd0) begin
        is_final = 1'b1;
        pa       = leaf_pa(entry, va, 1'b0);
      end else if (gran == 2'd2) begin
        is_final = 1'b1;
        pa       = leaf_pa(entry, va, 1'b1);
      end else begin
        is_fault = 1'b1;
        cause    = CZ_BADRESP;
      end
    end
  end
endmodule

// File: rtl/dxw_wait_timer.sv
module dxw_wait_timer #(
  parameter int CFG_W    = 4,
  parameter int TO_SCALE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CFG_W-1:0] cfg,
  output logic             expired
);
  localparam int CNT_W = CFG_W + $clog2(TO_SCALE) + 2;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit   = CNT_W'((32'(cfg) + 32'd1) * 32'(TO_SCALE));
  assign expired = run && (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/dxw_fault_log.sv
module dxw_fault_log
  import dxw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_evt,
  input  cause_t            cause,
  input  logic [RID_W-1:0]  rid,
  input  logic [VA_W-1:0]   va,
  input  logic              fault_en,
  input  logic              wr,
  input  logic [ENT_W-1:0]  wdata,
  output logic [ENT_W-1:0]  word,
  output logic              irq
);
  logic held;
  logic take;
  logic release_req;

  assign held        = word[63];
  assign take        = fault_evt && fault_en && !held;
  assign release_req = wr && !wdata[62] && held;
  assign irq         = held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           word <= '0;
    else if (take)        word <= pack_status(cause, rid, va);
    else if (release_req) word <= '0;
  end
endmodule

// File: rtl/dxw_walker.sv
module dxw_walker
  import dxw_pkg::*;
#(
  parameter int CFG_W    = 4,
  parameter int TO_SCALE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [15:0]      req_rid,
  input  logic [31:0]      req_va,
  output logic             resp_valid,
  output logic             resp_fault,
  output logic [2:0]       resp_cause,
  output logic [47:0]      resp_paddr,
  output logic             mem_req,
  output logic [47:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [63:0]      mem_rdata,
  input  logic [47:0]      dt_base,
  input  logic             fault_en,
  input  logic [CFG_W-1:0] timeout_cfg,
  input  logic             status_wr,
  input  logic [63:0]      status_wdata,
  output logic [63:0]      status_word,
  output logic             irq
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_t;

  st_t                st_q;
  level_t             lvl_q;
  logic [RID_W-1:0]   rid_q;
  logic [VA_W-1:0]    va_q;
  logic [PA_W-1:0]    base_q;

  logic               dec_fault, dec_final, dec_pass;
  cause_t             dec_cause;
  logic [PA_W-1:0]    dec_pa, dec_next;
  logic               timed_out;

  // Named walk events used by the FSM, the fault log and the checker.
  logic               accept_evt;
  logic               data_evt;
  logic               timeout_evt;
  logic               fault_evt;
  logic               done_evt;
  logic               pass_evt;
  cause_t             evt_cause;

  assign req_ready   = (st_q == ST_IDLE);
  assign accept_evt  = req_valid && req_ready;
  assign data_evt    = (st_q == ST_WAIT) && mem_rvalid;
  assign timeout_evt = (st_q == ST_WAIT) && !mem_rvalid && timed_out;
  assign fault_evt   = (data_evt && dec_fault) || timeout_evt;
  assign done_evt    = (data_evt && (dec_fault || dec_final)) || timeout_evt;
  assign pass_evt    = data_evt && dec_pass;
  assign evt_cause   = timeout_evt ? CZ_BADRESP : dec_cause;
  assign mem_req     = (st_q == ST_ISSUE);

  dxw_addr_gen u_addr (
    .lvl  (lvl_q),
    .base (base_q),
    .rid  (rid_q),
    .va   (va_q),
    .addr (mem_addr)
  );

  dxw_entry_dec u_dec (
    .lvl       (lvl_q),
    .entry     (mem_rdata),
    .va        (va_q),
    .is_fault  (dec_fault),
    .is_final  (dec_final),
    .pass_hit  (dec_pass),
    .cause     (dec_cause),
    .pa        (dec_pa),
    .next_base (dec_next)
  );

  dxw_wait_timer #(.CFG_W(CFG_W), .TO_SCALE(TO_SCALE)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st_q == ST_WAIT),
    .cfg     (timeout_cfg),
    .expired (timed_out)
  );

  dxw_fault_log u_log (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_evt (fault_evt),
    .cause     (evt_cause),
    .rid       (rid_q),
    .va        (va_q),
    .fault_en  (fault_en),
    .wr        (status_wr),
    .wdata     (status_wdata),
    .word      (status_word),
    .irq       (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lvl_q  <= LV_DEV1;
      rid_q  <= '0;
      va_q   <= '0;
      base_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept_evt) begin
          st_q   <= ST_ISSUE;
          lvl_q  <= LV_DEV1;
          rid_q  <= req_rid;
          va_q   <= req_va;
          base_q <= page_align(dt_base);
        end
        ST_ISSUE: st_q <= ST_WAIT;
        default: begin
          if (done_evt) begin
            st_q <= ST_IDLE;
          end else if (data_evt) begin
            st_q   <= ST_ISSUE;
            lvl_q  <= level_t'(lvl_q + 2'd1);
            base_q <= dec_next;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_cause <= '0;
      resp_paddr <= '0;
    end else begin
      resp_valid <= done_evt;
      if (done_evt) begin
        resp_fault <= fault_evt;
        resp_cause <= fault_evt ? evt_cause : 3'd0;
        resp_paddr <= fault_evt ? '0 : dec_pa;
      end
    end
  end
endmodule

// File: rtl/dxw_walker_chk.sv
module dxw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        resp_valid,
  input logic        resp_fault,
  input logic [2:0]  resp_cause,
  input logic [47:0] resp_paddr,
  input logic        mem_req,
  input logic [63:0] status_word,
  input logic        status_wr,
  input logic [63:0] status_wdata,
  input logic        irq,
  input logic        pass_evt,
  input logic [31:0] va_q
);
  assert_single_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_busy_while_reading_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  assert_sticky_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[63] && !(status_wr && !status_wdata[62])) |=> $stable(status_word));

  assert_irq_from_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (resp_valid && resp_fault));

  assert_passthru_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pass_evt |=> (resp_valid && !resp_fault && resp_paddr == {16'h0, $past(va_q)}));

  assert_cause_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_cause <= 3'd5 && resp_paddr == 48'h0));
endmodule

bind dxw_walker dxw_walker_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .resp_valid   (resp_valid),
  .resp_fault   (resp_fault),
  .resp_cause   (resp_cause),
  .resp_paddr   (resp_paddr),
  .mem_req      (mem_req),
  .status_word  (status_word),
  .status_wr    (status_wr),
  .status_wdata (status_wdata),
  .irq          (irq),
  .pass_evt     (pass_evt),
  .va_q         (va_q)
);

// File: tb/dxw_walker_tb.sv
module dxw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_rid = '0;
  logic [31:0] req_va = '0;
  logic        resp_valid, resp_fault;
  logic [2:0]  resp_cause;
  logic [47:0] resp_paddr;
  logic        mem_req;
  logic [47:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic [47:0] dt_base = 48'h0000_0010_0000;
  logic        fault_en = 1'b1;
  logic [3:0]  timeout_cfg = 4'hF;
  logic        status_wr = 1'b0;
  logic [63:0] status_wdata = '0;
  logic [63:0] status_word;
  logic        irq;

  always #5 clk = ~clk;

  dxw_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rid(req_rid), .req_va(req_va), .resp_valid(resp_valid),
    .resp_fault(resp_fault), .resp_cause(resp_cause), .resp_paddr(resp_paddr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .dt_base(dt_base), .fault_en(fault_en),
    .timeout_cfg(timeout_cfg), .status_wr(status_wr), .status_wdata(status_wdata),
    .status_word(status_word), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;

  logic [63:0] mem_img [logic [47:0]];
  logic [47:0] alog [0:7];
  int          alog_n = 0;
  bit          mute = 1'b0;
  int          rd_lat = 1;

  logic        r_fault;
  logic [2:0]  r_cause;
  logic [47:0] r_pa;
  int          r_cyc;

  localparam logic [47:0] DT2 = 48'h20_0000;
  localparam logic [47:0] PTR = 48'h30_0000;
  localparam logic [47:0] PT2 = 48'h40_0000;

  function automatic logic [63:0] mk(input logic [47:0] base, input logic [63:0] flags);
    logic [63:0] b;
    b = {16'h0, base} & 64'h0000_FFFF_FFFF_E000;
    return 64'h8000_0000_0000_0000 | b | flags;
  endfunction

  function automatic logic [47:0] a_d1(input logic [15:0] rid);
    return (dt_base & ~48'h1FFF) + 48'(rid / 256) * 8;
  endfunction
  function automatic logic [47:0] a_d2(input logic [15:0] rid);
    return DT2 + 48'(rid % 256) * 8;
  endfunction
  function automatic logic [47:0] a_p1(input logic [31:0] va);
    return PTR + 48'((va / 8192 / 1024) % 512) * 8;
  endfunction
  function automatic logic [47:0] a_p2(input logic [31:0] va);
    return PT2 + 48'((va / 8192) % 1024) * 8;
  endfunction
  function automatic logic [63:0] exp_stat(input int c, input logic [15:0] rid,
                                           input logic [31:0] va);
    return (64'h1 << 63) | (64'h1 << 62) | (64'(c) << 59) | (64'(rid) << 37) | 64'(va);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic build(input logic [15:0] rid, input logic [31:0] va,
                       input logic [63:0] leaf);
    mem_img.delete();
    mem_img[a_d1(rid)] = mk(DT2, 64'h0);
    mem_img[a_d2(rid)] = mk(PTR, 64'h0);
    mem_img[a_p1(va)]  = mk(PT2, 64'h0);
    mem_img[a_p2(va)]  = leaf;
  endtask

  // Memory responder: one reply per request, after rd_lat edges.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [47:0] a;
        a = mem_addr;
        if (alog_n < 8) alog[alog_n] = a;
        alog_n++;
        if (!mute) begin
          repeat (rd_lat) @(posedge clk);
          #1 mem_rvalid = 1'b1;
          mem_rdata = mem_img.exists(a) ? mem_img[a] : 64'h0;
          @(posedge clk);
          #1 mem_rvalid = 1'b0;
        end
      end
    end
  end

  task automatic xlate(input logic [15:0] rid, input logic [31:0] va);
    alog_n = 0;
    @(posedge clk); #1 req_valid = 1'b1; req_rid = rid; req_va = va;
    @(posedge clk); #1 req_valid = 1'b0;
    r_cyc = 0;
    do begin
      @(negedge clk);
      r_cyc++;
      if (r_cyc > 1 && !resp_valid)
        chk(!req_ready, "R9 busy during walk", 64'(req_ready), 64'h0);
    end while (!resp_valid && r_cyc < 500);
    r_fault = resp_fault;
    r_cause = resp_cause;
    r_pa    = resp_paddr;
    @(negedge clk);
    chk(!resp_valid, "R9 response lasts one cycle", 64'(resp_valid), 64'h0);
  endtask

  task automatic wr_status(input logic [63:0] d);
    @(posedge clk); #1 status_wr = 1'b1; status_wdata = d;
    @(posedge clk); #1 status_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(req_ready === 1'b1, "R1 ready", 64'(req_ready), 64'h1);
    chk(mem_req === 1'b0 && resp_valid === 1'b0, "R1 idle outputs",
        {62'h0, mem_req, resp_valid}, 64'h0);
    chk(status_word === 64'h0 && irq === 1'b0, "R1 status clear", status_word, 64'h0);
  endtask

  task automatic t_8k;
    logic [15:0] rid = 16'h0312;
    logic [31:0] va  = 32'h1234_5678;
    logic [47:0] lb  = 48'h00AB_CDEF_E000;
    build(rid, va, mk(lb, 64'h4000_0000_0000_0000));
    xlate(rid, va);
    chk(!r_fault, "R5 8K no fault", 64'(r_fault), 64'h0);
    chk(r_pa == lb + 48'(va % 8192), "R5 8K address", 64'(r_pa), 64'(lb + 48'(va % 8192)));
    chk(alog_n == 4, "R4 four reads", 64'(alog_n), 64'd4);
    chk(alog[0] == a_d1(rid) && alog[1] == a_d2(rid), "R2 device slots",
        64'(alog[1]), 64'(a_d2(rid)));
    chk(alog[2] == a_p1(va) && alog[3] == a_p2(va), "R4 page slots",
        64'(alog[3]), 64'(a_p2(va)));
  endtask

  task automatic t_8m;
    logic [15:0] rid = 16'hA7C1;
    logic [31:0] va  = 32'hF0F5_4321;
    logic [47:0] lb  = 48'h0001_0080_6000;
    rd_lat = 3;
    build(rid, va, mk(lb, 64'h4000_0000_0000_0020));
    xlate(rid, va);
    rd_lat = 1;
    chk(!r_fault, "R5 8M no fault", 64'(r_fault), 64'h0);
    chk(r_pa == (lb & ~48'h7F_FFFF) + 48'(va % (1 << 23)), "R5 8M address",
        64'(r_pa), 64'((lb & ~48'h7F_FFFF) + 48'(va % (1 << 23))));
    chk(alog[2] == a_p1(va), "R4 top index from high bits", 64'(alog[2]), 64'(a_p1(va)));
  endtask

  task automatic t_pass;
    logic [15:0] rid = 16'h0512;
    logic [31:0] va  = 32'hDEAD_BEEF;
    build(rid, va, 64'h0);
    mem_img[a_d2(rid)] = mk(PTR, 64'h1);
    xlate(rid, va);
    chk(!r_fault && r_pa == 48'(va), "R3 identity", 64'(r_pa), 64'(va));
    chk(alog_n == 2, "R3 two reads", 64'(alog_n), 64'd2);
  endtask

  task automatic t_sticky;
    logic [15:0] rid = 16'h0312;
    logic [31:0] va  = 32'h0000_4000;
    logic [63:0] held;
    build(rid, va, mk(48'h5000_0000, 64'h4000_0000_0000_0000));
    mem_img[a_d1(rid)] = 64'h0;
    xlate(rid, va);
    chk(r_fault && r_cause == 3'd0, "R6 cause 0", 64'(r_cause), 64'h0);
    held = exp_stat(0, rid, va);
    chk(status_word == held, "R7 status packing", status_word, held);
    chk(irq == 1'b1, "R8 irq raised", 64'(irq), 64'h1);
    build(rid, 32'h0000_6000, mk(48'h5000_0000, 64'h4000_0000_0000_0000));
    mem_img[a_d2(rid)] = mk(PTR, 64'h0) & ~(64'h1 << 63);
    xlate(rid, 32'h0000_6000);
    chk(r_fault && r_cause == 3'd1, "R6 cause 1", 64'(r_cause), 64'h1);
    chk(status_word == held, "R7 sticky word kept", status_word, held);
    wr_status(status_word);
    chk(status_word == held, "R8 write with bit62 set ignored", status_word, held);
    wr_status(status_word & ~(64'h1 << 62));
    chk(status_word == 64'h0 && irq == 1'b0, "R8 release", status_word, 64'h0);
  endtask

  task automatic t_pg_faults;
    logic [15:0] rid = 16'h2201;
    logic [31:0] va  = 32'h0ABC_2000;
    build(rid, va, mk(48'h6000_0000, 64'h4000_0000_0000_0000));
    mem_img[a_p1(va)] = 64'h0;
    xlate(rid, va);
    chk(r_fault && r_cause == 3'd2, "R6 cause 2", 64'(r_cause), 64'h2);
    wr_status(64'h0);
    build(rid, va, 64'h0000_0000_6000_0000);
    xlate(rid, va);
    chk(r_fault && r_cause == 3'd3 && r_pa == 48'h0, "R6 cause 3", 64'(r_cause), 64'h3);
    wr_status(64'h0);
    build(rid, va, mk(48'h6000_0000, 64'h0));
    xlate(rid, va);
    chk(r_fault && r_cause == 3'd4, "R6 cause 4 no access", 64'(r_cause), 64'h4);
    chk(status_word == exp_stat(4, rid, va), "R7 cause 4 word", status_word,
        exp_stat(4, rid, va));
    wr_status(64'h0);
    build(rid, va, mk(48'h6000_0000, 64'h4000_0000_0000_0010));
    xlate(rid, va);
    chk(r_fault && r_cause == 3'd5, "R5 bad granularity", 64'(r_cause), 64'h5);
    wr_status(64'h0);
  endtask

  task automatic t_noreport;
    logic [15:0] rid = 16'h0101;
    build(rid, 32'h100, 64'h0);
    mem_img[a_d1(rid)] = 64'h0;
    fault_en = 1'b0;
    xlate(rid, 32'h100);
    chk(r_fault && r_cause == 3'd0, "R8 fault still returned", 64'(r_cause), 64'h0);
    chk(status_word == 64'h0 && irq == 1'b0, "R8 not captured when disabled",
        status_word, 64'h0);
    fault_en = 1'b1;
  endtask

  task automatic t_timeout;
    logic [15:0] rid = 16'h0707;
    mute = 1'b1;
    timeout_cfg = 4'd2;
    xlate(rid, 32'h8000_0000);
    chk(r_fault && r_cause == 3'd5, "R10 timeout cause", 64'(r_cause), 64'h5);
    chk(r_cyc == 14, "R10 timeout latency", 64'(r_cyc), 64'd14);
    chk(status_word == exp_stat(5, rid, 32'h8000_0000), "R10 timeout captured",
        status_word, exp_stat(5, rid, 32'h8000_0000));
    mute = 1'b0;
    timeout_cfg = 4'hF;
    wr_status(64'h0);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        fails++;
        checks++;
        $display("FAIL R9 watchdog actual=%0d expected<100000", wd);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_8k();
    t_8m();
    t_pass();
    t_sticky();
    t_pg_faults();
    t_noreport();
    t_timeout();
    t_8k();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule